// File: doc/BRIEF.md
# SPI Register Access Command Framer

This engine sits on the host side of a byte-wide, full-duplex SPI link to a peripheral. It takes one register request, which is a read or a write with a 32-bit address and 32-bit write data, and turns it into the byte stream the peripheral expects. It then walks through the reply, checks it, and reports the read data with a pass/fail flag. The engine does not shift bits itself. It hands one byte at a time to an external shifter and waits for the byte clocked in during that exchange.

The command form depends on the address. Addresses below the `INT_LIMIT` parameter use a short internal form with two address bytes. These accesses are treated as clockless, so the echoed opcode and the status byte are not checked for them. All other addresses use the full form with three address bytes. A CRC7 trailer can be appended to the command. On a read, the engine searches a bounded window of reply bytes for the data-start marker. It then collects four data bytes, optionally followed by a CRC-16 that it checks.

Top module: `reg_access_framer`

## Requirements
- R1: A request whose address is below `INT_LIMIT` uses the internal form. Any other address uses the full form. The opcode byte is 0xCA for a full read, 0xC9 for a full write, 0xC4 for an internal read and 0xC3 for an internal write.
- R2: The full form sends the opcode, then address bits 23:16, 15:8 and 7:0. A write follows these with data bits 31:24, 23:16, 15:8 and 7:0.
- R3: The internal form sends the opcode, then address bits 15:8 with bit 7 forced to 1, then address bits 7:0. A read adds one 0x00 byte. A write adds the four data bytes, most significant first.
- R4: When `crc7En` is 1 at request time, one extra command byte follows. It is {crc, 1'b0}, where crc is the CRC-7 with polynomial x^7+x^3+1 and preset 0x7F, taken MSB-first over every preceding command byte.
- R5: After the command, two reply bytes are read: the echo and the status. For the full form, the transaction fails if the echo differs from the opcode or if the status is not 0x00.
- R6: For the internal form, the echo and status bytes never cause a failure.
- R7: On a read, up to `HUNT_WINDOW` bytes after the status byte are examined. The first byte whose upper nibble is 0xF is the data start. If none of them qualifies, the transaction fails and ends after exactly `HUNT_WINDOW` hunt bytes.
- R8: The four bytes after the data start are the read data. The first one received lands in `rdData[7:0]` and the last one in `rdData[31:24]`.
- R9: When `crc16En` is 1 at request time, a read fetches two more bytes, the high byte first. These are compared with the CRC-16 (polynomial 0x1021, preset 0xFFFF, MSB-first) over the four data bytes in the order received. A mismatch fails a full-form read only.
- R10: Every byte sent after the command bytes and the CRC7 byte is 0x00.
- R11: Only one byte is outstanding at a time. After reset, `spiTxValid` and `done` are low. `done` is a one-cycle pulse, and `err` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a request; taken only while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Register address |
| reqWdata | input | 32 | Write data |
| crc7En | input | 1 | Append CRC7 to the command |
| crc16En | input | 1 | Expect a CRC-16 after read data |
| spiTxValid | output | 1 | One-cycle pulse: shifter should exchange `spiTxByte` |
| spiTxByte | output | 8 | Byte to send |
| spiRxValid | input | 1 | Shifter finished the exchange |
| spiRxByte | input | 8 | Byte received, valid with `spiRxValid` |
| done | output | 1 | Transaction finished (one cycle) |
| err | output | 1 | Transaction failed, valid with `done` |
| rdData | output | 32 | Read data |

## Verification
The bench builds the engine with `INT_LIMIT` = 0x8000 and `HUNT_WINDOW` = 8. With these values, random addresses land on both sides of the form boundary, and the directed cases can probe the addresses 0x7FFF and 0x8000. The window of eight lets the bench reach both edges of the hunt: seven filler bytes before the marker must pass, and eight must fail after exactly eight hunt bytes. The shifter model's reply latency varies from byte to byte. Because the CRC7 engine needs eight clocks per byte, this makes the command phase wait on the CRC as well as on the link.

// File: rtl/raf_pkg.sv
package raf_pkg;

  localparam logic [7:0] OP_FULL_RD = 8'hCA;
  localparam logic [7:0] OP_FULL_WR = 8'hC9;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new request
    logic cmdShift;  // command byte launched: advance buffer, start CRC7
    logic selCmd;    // transmit from command buffer
    logic selCrc;    // transmit CRC7 trailer
    logic dataCap;   // capture a read data byte
    logic crcHiCap;  // capture received CRC-16 high byte
  } rafStrobe_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_CRC7, S_ECHO, S_STAT, S_HUNT, S_DATA, S_CRCH, S_CRCL, S_FIN
  } rafState_t;

endpackage

// File: rtl/raf_dpath.sv
module raf_dpath
  import raf_pkg::*;
#(
  parameter logic [31:0] INT_LIMIT = 32'h0000_8000
) (
  input  logic        clk,
  input  logic        rstN,
  input  rafStrobe_t  stb,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic [7:0]  rxByte,
  output logic [7:0]  txByte,
  output logic [3:0]  cmdLen,
  output logic        isInt,
  output logic        isRead,
  output logic        echoOk,
  output logic        statOk,
  output logic        startSeen,
  output logic        crc16Ok,
  output logic        crcBusy,
  output logic [31:0] rdData
);

  localparam int BUF_W = 64;

  function automatic logic [6:0] crc7Step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [15:0] crc16Byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[15] ^ d[k]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  logic [BUF_W-1:0] cmdBuf, cmdNext;
  logic [3:0]       lenNext;
  logic [7:0]       opNext, opQ, hiB;
  logic             intNext;
  logic [6:0]       crcReg;
  logic [7:0]       crcSh;
  logic [3:0]       crcCnt;
  logic [15:0]      crc16Reg;
  logic [7:0]       crcRxHi;

  // command image, left aligned
  always_comb begin
    intNext = reqAddr < INT_LIMIT;
    hiB     = reqAddr[15:8] | 8'h80;
    if (intNext) begin
      opNext = reqWrite ? OP_INT_WR : OP_INT_RD;
      if (reqWrite) begin
        cmdNext = {opNext, hiB, reqAddr[7:0], reqWdata, 8'h00};
        lenNext = 4'd7;
      end else begin
        cmdNext = {opNext, hiB, reqAddr[7:0], 8'h00, 32'h0};
        lenNext = 4'd4;
      end
    end else begin
      opNext = reqWrite ? OP_FULL_WR : OP_FULL_RD;
      if (reqWrite) begin
        cmdNext = {opNext, reqAddr[23:0], reqWdata};
        lenNext = 4'd8;
      end else begin
        cmdNext = {opNext, reqAddr[23:0], 32'h0};
        lenNext = 4'd4;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBuf <= '0;
      cmdLen <= '0;
      opQ    <= '0;
      isInt  <= 1'b0;
      isRead <= 1'b0;
    end else if (stb.load) begin
      cmdBuf <= cmdNext;
      cmdLen <= lenNext;
      opQ    <= opNext;
      isInt  <= intNext;
      isRead <= !reqWrite;
    end else if (stb.cmdShift) begin
      cmdBuf <= {cmdBuf[BUF_W-9:0], 8'h00};
    end
  end

  // serial CRC7: one bit per clock, started when a command byte leaves
  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= 7'h7F;
      crcSh  <= '0;
      crcCnt <= '0;
    end else begin
      if (stb.load) begin
        crcReg <= 7'h7F;
      end else if (crcCnt != 4'd0) begin
        crcReg <= crc7Step(crcReg, crcSh[7]);
        crcSh  <= {crcSh[6:0], 1'b0};
        crcCnt <= crcCnt - 4'd1;
      end
      if (stb.cmdShift) begin
        crcSh  <= cmdBuf[BUF_W-1 -: 8];
        crcCnt <= 4'd8;
      end
    end
  end

  assign crcBusy = crcCnt != 4'd0;

  // read data and CRC-16
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      crc16Reg <= 16'hFFFF;
      crcRxHi  <= '0;
    end else if (stb.load) begin
      rdData   <= '0;
      crc16Reg <= 16'hFFFF;
    end else begin
      if (stb.dataCap) begin
        rdData   <= {rxByte, rdData[31:8]};
        crc16Reg <= crc16Byte(crc16Reg, rxByte);
      end
      if (stb.crcHiCap) crcRxHi <= rxByte;
    end
  end

  assign txByte    = stb.selCrc ? {crcReg, 1'b0} :
                     stb.selCmd ? cmdBuf[BUF_W-1 -: 8] : 8'h00;
  assign echoOk    = rxByte == opQ;
  assign statOk    = rxByte == 8'h00;
  assign startSeen = rxByte[7:4] == 4'hF;
  assign crc16Ok   = {crcRxHi, rxByte} == crc16Reg;

  AST_CRC_IDLE_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.selCrc |-> (crcCnt <= 4'd8)) else $error("crc counter out of range"); // R4

endmodule

// File: rtl/raf_ctrl.sv
module raf_ctrl
  import raf_pkg::*;
#(
  parameter int HUNT_WINDOW = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       crc7En,
  input  logic       crc16En,
  input  logic       spiRxValid,
  input  logic [3:0] cmdLen,
  input  logic       isInt,
  input  logic       isRead,
  input  logic       echoOk,
  input  logic       statOk,
  input  logic       startSeen,
  input  logic       crc16Ok,
  input  logic       crcBusy,
  output rafStrobe_t stb,
  output logic       spiTxValid,
  output logic       done,
  output logic       err
);

  localparam int CNT_W = $clog2(HUNT_WINDOW + 9);

  rafState_t        state;
  logic [CNT_W-1:0] cnt, lenM1;
  logic             inFlight, errQ, c7Q, c16Q;
  logic             txState, launch, rxEv;

  assign txState = (state != S_IDLE) && (state != S_FIN);
  assign launch  = txState && !inFlight && !crcBusy;
  assign rxEv    = inFlight && spiRxValid;
  assign lenM1   = CNT_W'(cmdLen) - CNT_W'(1);

  always_comb begin
    stb          = '0;
    stb.load     = (state == S_IDLE) && reqValid;
    stb.selCmd   = state == S_CMD;
    stb.cmdShift = launch && (state == S_CMD);
    stb.selCrc   = state == S_CRC7;
    stb.dataCap  = rxEv && (state == S_DATA);
    stb.crcHiCap = rxEv && (state == S_CRCH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      inFlight <= 1'b0;
      errQ     <= 1'b0;
      c7Q      <= 1'b0;
      c16Q     <= 1'b0;
    end else begin
      if (launch)          inFlight <= 1'b1;
      else if (spiRxValid) inFlight <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          state <= S_CMD;
          cnt   <= '0;
          errQ  <= 1'b0;
          c7Q   <= crc7En;
          c16Q  <= crc16En;
        end
        S_CMD: if (rxEv) begin
          cnt <= cnt + 1'b1;
          if (cnt == lenM1) state <= c7Q ? S_CRC7 : S_ECHO;
        end
        S_CRC7: if (rxEv) state <= S_ECHO;
        S_ECHO: if (rxEv) begin
          if (!isInt && !echoOk) errQ <= 1'b1;
          state <= S_STAT;
        end
        S_STAT: if (rxEv) begin
          if (!isInt && !statOk) errQ <= 1'b1;
          state <= isRead ? S_HUNT : S_FIN;
          cnt   <= '0;
        end
        S_HUNT: if (rxEv) begin
          if (startSeen) begin
            state <= S_DATA;
            cnt   <= '0;
          end else if (cnt == CNT_W'(HUNT_WINDOW - 1)) begin
            errQ  <= 1'b1;
            state <= S_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (rxEv) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(3)) state <= c16Q ? S_CRCH : S_FIN;
        end
        S_CRCH: if (rxEv) state <= S_CRCL;
        S_CRCL: if (rxEv) begin
          if (!isInt && !crc16Ok) errQ <= 1'b1;
          state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign spiTxValid = launch;
  assign done       = state == S_FIN;
  assign err        = errQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    spiTxValid |=> !spiTxValid) else $error("second byte launched before reply"); // R11
  AST_HUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HUNT) |-> (cnt < CNT_W'(HUNT_WINDOW))) else $error("hunt past window"); // R7
  AST_CMD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMD) |-> (cnt < CNT_W'(cmdLen))) else $error("command overrun"); // R2
  AST_INT_ECHO_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (rxEv && isInt && (state == S_ECHO || state == S_STAT)) |=> $stable(errQ))
    else $error("internal echo/status flagged"); // R6
  AST_INT_CRC16_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (rxEv && isInt && state == S_CRCL) |=> $stable(errQ))
    else $error("internal crc16 flagged"); // R9

endmodule

// File: rtl/reg_access_framer.sv
module reg_access_framer
  import raf_pkg::*;
#(
  parameter logic [31:0] INT_LIMIT   = 32'h0000_8000,
  parameter int          HUNT_WINDOW = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic        crc7En,
  input  logic        crc16En,
  output logic        spiTxValid,
  output logic [7:0]  spiTxByte,
  input  logic        spiRxValid,
  input  logic [7:0]  spiRxByte,
  output logic        done,
  output logic        err,
  output logic [31:0] rdData
);

  rafStrobe_t stb;
  logic [3:0] cmdLen;
  logic       isInt, isRead, echoOk, statOk, startSeen, crc16Ok, crcBusy;

  raf_ctrl #(.HUNT_WINDOW(HUNT_WINDOW)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .crc7En(crc7En), .crc16En(crc16En),
    .spiRxValid(spiRxValid), .cmdLen(cmdLen), .isInt(isInt), .isRead(isRead),
    .echoOk(echoOk), .statOk(statOk), .startSeen(startSeen), .crc16Ok(crc16Ok),
    .crcBusy(crcBusy), .stb(stb), .spiTxValid(spiTxValid), .done(done), .err(err)
  );

  raf_dpath #(.INT_LIMIT(INT_LIMIT)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rxByte(spiRxByte), .txByte(spiTxByte), .cmdLen(cmdLen),
    .isInt(isInt), .isRead(isRead), .echoOk(echoOk), .statOk(statOk),
    .startSeen(startSeen), .crc16Ok(crc16Ok), .crcBusy(crcBusy), .rdData(rdData)
  );

endmodule

// File: tb/test_reg_access_framer.sv
module test_reg_access_framer;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] LIMIT      = 32'h0000_8000;
  localparam int          HW         = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, crc7En = 1'b0, crc16En = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic        spiTxValid, spiRxValid = 1'b0, done, err;
  logic [7:0]  spiTxByte, spiRxByte = '0;
  logic [31:0] rdData;

  int errors = 0;
  int checks = 0;
  logic [7:0] rxScript [0:63];
  logic [7:0] txLog    [0:63];
  int txCount = 0;

  reg_access_framer #(.INT_LIMIT(LIMIT), .HUNT_WINDOW(HW)) i_reg_access_framer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .crc7En(crc7En), .crc16En(crc16En), .spiTxValid(spiTxValid),
    .spiTxByte(spiTxByte), .spiRxValid(spiRxValid), .spiRxByte(spiRxByte),
    .done(done), .err(err), .rdData(rdData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc7Of(input logic [7:0] b [0:8], input int n);
    logic [6:0] c = 7'h7F;
    for (int i = 0; i < n; i++)
      for (int k = 7; k >= 0; k--)
        c = (c[6] ^ b[i][k]) ? ({c[5:0], 1'b0} ^ 7'h09) : {c[5:0], 1'b0};
    return {c, 1'b0};
  endfunction

  function automatic logic [15:0] crc16Of(input logic [31:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 4; i++)
      for (int k = 7; k >= 0; k--)
        c = (c[15] ^ d[8*i + k]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    return c;
  endfunction

  // shifter model: answers each launched byte after a random latency
  initial begin
    forever begin
      @(negedge clk);
      spiRxValid = 1'b0;
      if (spiTxValid) begin
        int idx;
        int lat;
        idx = txCount;
        if (idx < 64) txLog[idx] = spiTxByte;
        txCount++;
        lat = 1 + int'($urandom % 3);
        repeat (lat) @(negedge clk);
        spiRxByte  = (idx < 64) ? rxScript[idx] : 8'h00;
        spiRxValid = 1'b1;
      end
    end
  end

  task automatic runTxn(input bit wr, input logic [31:0] addr, input logic [31:0] wdata,
                        input bit c7, input bit c16, input int nFill, input bit badEcho,
                        input bit badStat, input bit badCrc, input logic [31:0] datum,
                        input string tag);
    logic [7:0]  cmd [0:8];
    logic [7:0]  op;
    logic [15:0] cv;
    bit isInt, expErr, cmdOk, zeroOk, hasData;
    int n, pos, expCount, waitCyc;
    for (int i = 0; i < 9; i++) cmd[i] = 8'h00;
    isInt = addr < LIMIT;
    op = wr ? (isInt ? 8'hC3 : 8'hC9) : (isInt ? 8'hC4 : 8'hCA);
    cmd[0] = op;
    if (isInt) begin
      cmd[1] = addr[15:8] | 8'h80;
      cmd[2] = addr[7:0];
      if (wr) begin
        for (int i = 0; i < 4; i++) cmd[3+i] = wdata[31-8*i -: 8];
        n = 7;
      end else begin
        cmd[3] = 8'h00;
        n = 4;
      end
    end else begin
      cmd[1] = addr[23:16]; cmd[2] = addr[15:8]; cmd[3] = addr[7:0];
      n = 4;
      if (wr) begin
        for (int i = 0; i < 4; i++) cmd[4+i] = wdata[31-8*i -: 8];
        n = 8;
      end
    end
    if (c7) begin
      cmd[n] = crc7Of(cmd, n);
      n++;
    end
    for (int i = 0; i < 64; i++) rxScript[i] = 8'h00;
    for (int i = 0; i < n; i++) rxScript[i] = 8'hA5;
    pos = n;
    rxScript[pos] = badEcho ? (op ^ 8'h01) : op; pos++;
    rxScript[pos] = badStat ? 8'h04 : 8'h00;     pos++;
    expCount = n + 2;
    expErr   = !isInt && (badEcho || badStat);
    hasData  = 1'b0;
    if (!wr) begin
      for (int f = 0; f < nFill && f < HW; f++) begin
        rxScript[pos] = (f % 2 == 1) ? 8'h00 : 8'hE7;
        pos++;
      end
      if (nFill >= HW) begin
        expCount += HW;
        expErr = 1'b1;
      end else begin
        hasData = 1'b1;
        rxScript[pos] = 8'hF5; pos++;
        for (int b = 0; b < 4; b++) begin
          rxScript[pos] = datum[8*b +: 8];
          pos++;
        end
        expCount += nFill + 5;
        if (c16) begin
          cv = crc16Of(datum);
          if (badCrc) cv = cv ^ 16'h0100;
          rxScript[pos] = cv[15:8]; pos++;
          rxScript[pos] = cv[7:0];  pos++;
          expCount += 2;
          if (badCrc && !isInt) expErr = 1'b1;
        end
      end
    end
    txCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wdata;
    crc7En = c7; crc16En = c16;
    @(negedge clk);
    reqValid = 1'b0;
    waitCyc = 0;
    while (!done && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
    end
    if (!done) begin
      chk(1'b0, {tag, " R11 no done"}, 64'(waitCyc), 64'(3000));
    end else begin
      chk(err == expErr, {tag, " err flag (R5 R6 R7 R9)"}, 64'(err), 64'(expErr));
      chk(txCount == expCount, {tag, " byte count (R7 R11)"}, 64'(txCount), 64'(expCount));
      cmdOk = 1'b1;
      for (int i = 0; i < n; i++) if (txLog[i] !== cmd[i]) cmdOk = 1'b0;
      chk(cmdOk, {tag, " command bytes (R1 R2 R3 R4)"}, {txLog[0], txLog[1], txLog[2], txLog[3]},
          {cmd[0], cmd[1], cmd[2], cmd[3]});
      zeroOk = 1'b1;
      for (int i = n; i < txCount && i < 64; i++) if (txLog[i] !== 8'h00) zeroOk = 1'b0;
      chk(zeroOk, {tag, " reply-phase bytes zero (R10)"}, 64'(zeroOk), 64'(1));
      if (hasData) chk(rdData == datum, {tag, " read data (R8)"}, 64'(rdData), 64'(datum));
      @(negedge clk);
      chk(!done, {tag, " done single pulse (R11)"}, 64'(done), 64'(0));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(!spiTxValid && !done, "R11 reset state", {62'(0), spiTxValid, done}, 64'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!spiTxValid && !done, "R11 idle after reset", {62'(0), spiTxValid, done}, 64'(0));

    runTxn(1, 32'h0012_3456, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0, "R2 full write");
    runTxn(1, 32'h00AB_CDEF, 32'h0102_0304, 1, 0, 0, 0, 0, 0, 0, "R4 full write crc7");
    runTxn(1, 32'h0000_1234, 32'hCAFE_F00D, 1, 0, 0, 0, 0, 0, 0, "R3 internal write crc7");
    runTxn(0, 32'h0000_0042, 0, 0, 0, 0, 0, 0, 0, 32'h8899_AABB, "R3 internal read");
    runTxn(0, 32'h0000_7FFF, 0, 1, 0, 2, 0, 0, 0, 32'h1122_3344, "R1 limit-1 internal");
    runTxn(0, 32'h0000_8000, 0, 1, 0, 2, 0, 0, 0, 32'h5566_7788, "R1 limit full");
    runTxn(0, 32'h0040_0000, 0, 0, 1, 0, 0, 0, 0, 32'hA1B2_C3D4, "R9 crc16 good");
    runTxn(0, 32'h0040_0004, 0, 0, 1, 1, 0, 0, 1, 32'h0F0E_0D0C, "R9 crc16 bad full");
    runTxn(0, 32'h0000_0100, 0, 0, 1, 1, 0, 0, 1, 32'h1357_9BDF, "R9 crc16 bad internal");
    runTxn(0, 32'h0000_0200, 0, 0, 0, 0, 1, 1, 0, 32'h2468_ACE0, "R6 internal echo/status");
    runTxn(1, 32'h0000_0300, 32'h7777_0000, 0, 0, 0, 1, 1, 0, 0, "R6 internal write echo");
    runTxn(0, 32'h0001_0000, 0, 0, 0, 0, 1, 0, 0, 32'hFFFF_0000, "R5 bad echo");
    runTxn(1, 32'h0001_0010, 32'h1, 0, 0, 0, 0, 1, 0, 0, "R5 bad status");
    runTxn(0, 32'h0002_0000, 0, 0, 0, HW - 1, 0, 0, 0, 32'h0BAD_F00D, "R7 max fillers");
    runTxn(0, 32'h0002_0004, 0, 1, 1, HW, 0, 0, 0, 32'h0, "R7 window missed");
    runTxn(0, 32'h0003_0000, 0, 1, 1, 3, 0, 0, 0, 32'h0000_0000, "R8 zero data");

    for (int t = 0; t < 60; t++) begin
      logic [31:0] a;
      int nf;
      a  = ($urandom % 2 == 0) ? ($urandom % LIMIT) : ($urandom | 32'h0001_0000);
      nf = int'($urandom % (HW + 2));
      runTxn(1'($urandom), a, $urandom, 1'($urandom), 1'($urandom), nf,
             ($urandom % 6 == 0), ($urandom % 6 == 0), ($urandom % 5 == 0), $urandom,
             "R1 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule